// File: doc/BRIEF.md
# Method-Call Dispatch Router

This block steers object method-invocation packets to hardware functional units. There is one unit for each (method, class) pair, so run-time dynamic binding becomes plain packet routing. A packet opens with a header word that carries a method code and an object identifier. The object identifier is a class field plus an instance number. Parameter words follow the header, and the final word carries a last flag. The router joins the method code and the class field into a unit index and delivers the whole packet, header included, to that unit's port. Every overriding definition of a virtual method shares one method code, so the class field alone decides which implementation receives the call.

A presence bitmap, written through a small configuration port, records which units are currently swapped in. When a header names an absent unit, the packet goes to a swapper port, which also receives the unit index. Writing a unit's bit to 1 stops the swapper claiming that index. Writing it back to 0 lets the swapper reclaim it.

Each unit has a clock-enable output. It rises as the unit's first word is presented and drops after the unit's last word has been taken. An idle unit can therefore stay gated, with a wake-up cost of one cycle. Input and output both use valid/ready handshakes. A packet stays bound to its port until its last word is taken. A blocked port stalls the input rather than dropping anything.

Top module: `mcr_dispatch_router`

## Requirements
- R1: After reset, in_ready is high once the internal reset release completes, and every unit_valid, swp_valid and unit_clk_en output is low.
- R2: The header word holds the method code in bits [15:14], the class field in bits [13:12] and the instance number in bits [11:8]. The unit index is {method, class}, so unit = method*4 + class. When that unit's presence bit is 1, the packet appears only on unit_valid[unit].
- R3: When the header's unit has presence bit 0, the packet appears only on swp_valid, with swp_unit equal to the computed unit index.
- R4: All words of a packet, header first, leave in arrival order with their last flag on the port chosen at the header. This holds even if presence changes mid-packet.
- R5: While the presented word is not taken, it stays stable on the same port and in_ready is low. No word is lost or duplicated.
- R6: unit_clk_en[u] rises in the cycle after a header for present unit u is accepted, which is the cycle its first word is presented. It falls in the cycle after u's last word is taken, unless a new header for u was accepted at the same edge. A word is never presented to a unit whose enable is low.
- R7: A presence write (cfg_we with cfg_unit and cfg_present) affects headers accepted at later edges. A header accepted at the same edge as the write uses the old value.
- R8: At most one of unit_valid and swp_valid is high in any cycle.
- R9: A word accepted at the input is presented at an output in the next cycle.
- R10: The instance number has no effect on the destination. Headers that differ only in bits [11:8] reach the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Router can take the input word |
| in_data | input | 16 | Input word: a header, then parameter words |
| in_last | input | 1 | Marks the final word of a packet |
| cfg_we | input | 1 | Presence bitmap write strobe |
| cfg_unit | input | 4 | Unit index to write |
| cfg_present | input | 1 | New presence value |
| unit_valid | output | 16 | Per-unit word valid |
| unit_ready | input | 16 | Per-unit ready |
| unit_clk_en | output | 16 | Per-unit clock enable (wake) |
| swp_valid | output | 1 | Swapper port word valid |
| swp_ready | input | 1 | Swapper ready |
| swp_unit | output | 4 | Unit index the swapper word was meant for |
| out_data | output | 16 | Word shared by all output ports |
| out_last | output | 1 | Last flag shared by all output ports |

## Verification
The main function is driven by four traffic patterns:
- Packets to random units with every port ready. This shows the plain {method, class} decode and full throughput.
- The same traffic with random per-port and swapper back-pressure. This separates a held word from a lost or duplicated one.
- Traffic after some units are marked absent. This shows whether the swapper claims exactly the cleared indices and whether virtual dispatch by class alone still picks different ports.
- A presence flip in the middle of a packet, and back-to-back packets to one unit. These show whether binding is fixed at the header and whether the wake enable stays up across consecutive calls.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned METHOD_W  = 2;
  localparam int unsigned CLASS_W   = 2;
  localparam int unsigned INST_W    = 4;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned UNIT_W    = METHOD_W + CLASS_W;
  localparam int unsigned NUM_UNITS = 1 << UNIT_W;

  typedef logic [UNIT_W-1:0] unit_t;

  typedef struct packed {
    logic  to_swp;
    unit_t unit;
  } route_t;

  // method code sits on top of the class field, so both together form the index
  function automatic unit_t hdr_unit(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: UNIT_W];
  endfunction
endpackage

// File: rtl/mcr_rst_sync.sv
module mcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/mcr_presence_map.sv
module mcr_presence_map #(
  parameter int unsigned     N       = 16,
  parameter int unsigned     IDX_W   = 4,
  parameter logic [N-1:0]    RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_present
);
  logic [N-1:0] map_q;
  logic [N-1:0] map_n;

  always_comb begin
    map_n = map_q;
    map_n[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     map_q <= RST_VAL;
    else if (wr_en) map_q <= map_n;
  end

  assign rd_present = map_q[rd_idx];
endmodule

// File: rtl/mcr_wake_ctrl.sv
module mcr_wake_ctrl #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     clk_en
);
  for (genvar u = 0; u < N; u++) begin : g_unit
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(u);
    logic hit_set, hit_clr, en_q, en_n;

    assign hit_set = set_en && (set_idx == MY_IDX);
    assign hit_clr = clr_en && (clr_idx == MY_IDX);

    // a new call arriving as the previous one finishes keeps the unit awake
    always_comb begin
      if (hit_set)      en_n = 1'b1;
      else if (hit_clr) en_n = 1'b0;
      else              en_n = en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  en_q <= 1'b0;
      else if (hit_set || hit_clr) en_q <= en_n;
    end

    assign clk_en[u] = en_q;
  end
endmodule

// File: rtl/mcr_dispatch_router.sv
module mcr_dispatch_router
  import mcr_pkg::*;
#(
  parameter logic [NUM_UNITS-1:0] PRESENT_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_data,
  input  logic                 in_last,
  input  logic                 cfg_we,
  input  logic [UNIT_W-1:0]    cfg_unit,
  input  logic                 cfg_present,
  output logic [NUM_UNITS-1:0] unit_valid,
  input  logic [NUM_UNITS-1:0] unit_ready,
  output logic [NUM_UNITS-1:0] unit_clk_en,
  output logic                 swp_valid,
  input  logic                 swp_ready,
  output logic [UNIT_W-1:0]    swp_unit,
  output logic [WORD_W-1:0]    out_data,
  output logic                 out_last
);
  logic   rst_n_s;
  unit_t  hdr_idx;
  logic   hdr_present;
  route_t hdr_route, cur_route;
  route_t bind_q, bind_n, oroute_q, oroute_n;
  logic   pkt_q, pkt_n;
  logic   ovld_q, ovld_n, olast_q, olast_n;
  logic [WORD_W-1:0] odata_q, odata_n;
  logic   in_acc, out_acc;

  mcr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign hdr_idx = hdr_unit(in_data);

  mcr_presence_map #(
    .N       (NUM_UNITS),
    .IDX_W   (UNIT_W),
    .RST_VAL (PRESENT_RST)
  ) u_presence (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (cfg_we),
    .wr_idx     (cfg_unit),
    .wr_val     (cfg_present),
    .rd_idx     (hdr_idx),
    .rd_present (hdr_present)
  );

  // routing: header words decode, later words reuse the bound destination
  always_comb begin
    hdr_route.to_swp = !hdr_present;
    hdr_route.unit   = hdr_idx;
    cur_route        = pkt_q ? bind_q : hdr_route;
  end

  assign out_acc  = ovld_q && (oroute_q.to_swp ? swp_ready : unit_ready[oroute_q.unit]);
  assign in_ready = rst_n_s && (!ovld_q || out_acc);
  assign in_acc   = in_valid && in_ready;

  // next-state
  always_comb begin
    ovld_n   = ovld_q;
    odata_n  = odata_q;
    olast_n  = olast_q;
    oroute_n = oroute_q;
    pkt_n    = pkt_q;
    bind_n   = bind_q;
    if (out_acc) ovld_n = 1'b0;
    if (in_acc) begin
      ovld_n   = 1'b1;
      odata_n  = in_data;
      olast_n  = in_last;
      oroute_n = cur_route;
      pkt_n    = !in_last;
      if (!pkt_q) bind_n = hdr_route;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovld_q   <= 1'b0;
      odata_q  <= '0;
      olast_q  <= 1'b0;
      oroute_q <= '0;
      pkt_q    <= 1'b0;
      bind_q   <= '0;
    end else begin
      if (in_acc || out_acc) ovld_q <= ovld_n;
      if (in_acc) begin
        odata_q  <= odata_n;
        olast_q  <= olast_n;
        oroute_q <= oroute_n;
        pkt_q    <= pkt_n;
        bind_q   <= bind_n;
      end
    end
  end

  mcr_wake_ctrl #(
    .N     (NUM_UNITS),
    .IDX_W (UNIT_W)
  ) u_wake (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_en  (in_acc && !pkt_q && hdr_present),
    .set_idx (hdr_idx),
    .clr_en  (out_acc && olast_q && !oroute_q.to_swp),
    .clr_idx (oroute_q.unit),
    .clk_en  (unit_clk_en)
  );

  assign unit_valid = (ovld_q && !oroute_q.to_swp) ?
                      (NUM_UNITS'(1) << oroute_q.unit) : '0;
  assign swp_valid  = ovld_q && oroute_q.to_swp;
  assign swp_unit   = oroute_q.unit;
  assign out_data   = odata_q;
  assign out_last   = olast_q;
endmodule

// File: rtl/mcr_dispatch_router_chk.sv
module mcr_dispatch_router_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] unit_valid,
  input logic [N-1:0] unit_ready,
  input logic [N-1:0] unit_clk_en,
  input logic         swp_valid,
  input logic         swp_ready,
  input logic [W-1:0] out_data,
  input logic         out_last
);
  logic stall;
  assign stall = (|(unit_valid & ~unit_ready)) || (swp_valid && !swp_ready);

  p_one_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unit_valid, swp_valid}));

  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ({unit_valid, swp_valid} == $past({unit_valid, swp_valid}))
              && $stable(out_data) && $stable(out_last));

  p_no_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready);

  p_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_valid & ~unit_clk_en) == '0);

  p_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ((|unit_valid) || swp_valid));
endmodule

bind mcr_dispatch_router mcr_dispatch_router_chk #(
  .N (mcr_pkg::NUM_UNITS),
  .W (mcr_pkg::WORD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .unit_valid  (unit_valid),
  .unit_ready  (unit_ready),
  .unit_clk_en (unit_clk_en),
  .swp_valid   (swp_valid),
  .swp_ready   (swp_ready),
  .out_data    (out_data),
  .out_last    (out_last)
);

// File: tb/mcr_dispatch_router_tb_top.sv
module mcr_dispatch_router_tb_top;
  localparam int NU = 16;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last;
  logic [WW-1:0] in_data;
  logic cfg_we, cfg_present;
  logic [3:0] cfg_unit;
  logic [NU-1:0] unit_valid, unit_ready, unit_clk_en;
  logic swp_valid, swp_ready;
  logic [3:0] swp_unit;
  logic [WW-1:0] out_data;
  logic out_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ready_mode = 0;

  always #5 clk = ~clk;

  mcr_dispatch_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_present(cfg_present),
    .unit_valid(unit_valid), .unit_ready(unit_ready), .unit_clk_en(unit_clk_en),
    .swp_valid(swp_valid), .swp_ready(swp_ready), .swp_unit(swp_unit),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [NU-1:0] m_pres, m_en;
  bit m_vld, m_last, m_swp, m_inpkt, m_bswp, m_first, prev_in_acc;
  bit [3:0] m_unit, m_bunit;
  bit [WW-1:0] m_data;
  int m_sync;

  always begin
    @(negedge clk); #2;
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", 64'(cycles), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      m_pres = '1; m_en = '0; m_vld = 0; m_inpkt = 0; m_sync = 0; prev_in_acc = 0;
    end else begin
      bit [NU-1:0] exp_uv;
      bit exp_sv, rst_done, m_acc, exp_rdy, in_acc, r_swp;
      bit [3:0] r_unit;
      rst_done = (m_sync == 2);
      exp_uv = (m_vld && !m_swp) ? (NU'(1) << m_unit) : '0;
      exp_sv = m_vld && m_swp;
      chk(unit_valid == exp_uv, "R2", 64'(unit_valid), 64'(exp_uv));
      chk(swp_valid == exp_sv, "R3", 64'(swp_valid), 64'(exp_sv));
      if (exp_sv) chk(swp_unit == m_unit, "R3", 64'(swp_unit), 64'(m_unit));
      if (m_vld) chk({out_data, out_last} == {m_data, m_last}, "R4",
                     64'({out_data, out_last}), 64'({m_data, m_last}));
      if (m_vld && m_first && m_data[11:8] != 0)
        chk(exp_sv ? swp_valid : (unit_valid == exp_uv), "R10", 64'(unit_valid), 64'(exp_uv));
      chk(unit_clk_en == m_en, "R6", 64'(unit_clk_en), 64'(m_en));
      chk($countones({unit_valid, swp_valid}) <= 1, "R8", 64'({unit_valid, swp_valid}), 64'd0);
      if (prev_in_acc) chk(unit_valid != 0 || swp_valid, "R9", 64'({unit_valid, swp_valid}), 64'd1);
      m_acc = m_vld && (m_swp ? swp_ready : unit_ready[m_unit]);
      exp_rdy = rst_done && (!m_vld || m_acc);
      chk(in_ready == exp_rdy, "R5", 64'(in_ready), 64'(exp_rdy));
      in_acc = in_valid && exp_rdy;
      prev_in_acc = in_acc;
      if (rst_done) begin
        if (m_inpkt) begin r_unit = m_bunit; r_swp = m_bswp; end
        else begin r_unit = in_data[15:12]; r_swp = !m_pres[in_data[15:12]]; end
        if (m_acc && m_last && !m_swp) m_en[m_unit] = 0;
        if (in_acc && !m_inpkt && !r_swp) m_en[r_unit] = 1;
        if (m_acc) m_vld = 0;
        if (in_acc) begin
          m_vld = 1; m_data = in_data; m_last = in_last;
          m_unit = r_unit; m_swp = r_swp; m_first = !m_inpkt;
          if (!m_inpkt) begin m_bunit = r_unit; m_bswp = r_swp; end
          m_inpkt = !in_last;
        end
        if (cfg_we) m_pres[cfg_unit] = cfg_present;
      end
      if (m_sync < 2) m_sync++;
    end
  end

  // downstream ready driver
  always begin
    @(negedge clk); #1;
    if (ready_mode == 0) begin unit_ready = '1; swp_ready = 1; end
    else begin unit_ready = NU'($urandom); swp_ready = $urandom_range(0, 1) == 1; end
  end

  task automatic send_word(input logic [WW-1:0] w, input bit last);
    bit ok;
    in_valid = 1; in_data = w; in_last = last;
    do begin
      #2 ok = in_ready;
      @(negedge clk); #1;
    end while (!ok);
    in_valid = 0;
  endtask

  task automatic send_pkt(input int m, input int c, input int inst, input int len);
    for (int k = 0; k < len; k++)
      send_word(k == 0 ? {2'(m), 2'(c), 4'(inst), 8'h00} : WW'($urandom), k == len - 1);
  endtask

  task automatic cfg_write(input int u, input bit v);
    cfg_we = 1; cfg_unit = 4'(u); cfg_present = v;
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_data = '0; in_last = 0;
    cfg_we = 0; cfg_unit = '0; cfg_present = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    #2;
    // R1: idle state after reset release
    chk(in_ready == 1, "R1", 64'(in_ready), 64'd1);
    chk(unit_valid == 0 && !swp_valid, "R1", 64'({unit_valid, swp_valid}), 64'd0);
    chk(unit_clk_en == 0, "R1", 64'(unit_clk_en), 64'd0);
    @(negedge clk); #1;
    // all ports ready
    for (int i = 0; i < 20; i++)
      send_pkt($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(1, 4));
    // back-pressure
    ready_mode = 1;
    for (int i = 0; i < 40; i++)
      send_pkt($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(1, 4));
    // R3 R7: mark units absent (includes method 1 under several classes)
    cfg_write(3, 0); cfg_write(5, 0); cfg_write(6, 0); cfg_write(12, 0);
    send_pkt(1, 0, 2, 2); send_pkt(1, 1, 9, 3); send_pkt(1, 2, 1, 1); send_pkt(1, 3, 0, 2);
    for (int i = 0; i < 30; i++)
      send_pkt($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(1, 4));
    // R4: presence flip while a packet is in flight
    cfg_write(9, 1);
    send_word({2'd2, 2'd1, 4'd7, 8'h00}, 0);
    fork
      cfg_write(9, 0);
      begin send_word(16'hA55A, 0); send_word(16'h1234, 1); end
    join
    send_pkt(2, 1, 3, 2);
    cfg_write(9, 1);
    send_pkt(2, 1, 4, 2);
    // R6: back-to-back calls to one unit
    ready_mode = 0;
    for (int i = 0; i < 6; i++) send_pkt(3, 2, i, 1 + (i % 3));
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule